// File: doc/BRIEF.md
# Quadrature Position Decoder

This block turns the two phase signals of an incremental rotary encoder and its once-per-revolution index marker into a signed-free position count. The two phases, the index and one spare input each pass through a two-flop synchronizer and a programmable glitch filter. The filtered phases are then decoded at four counts per line cycle, so the count steps up or down on every edge of either phase.

The position register has a programmable upper bound. Three selectable modes decide what the index marker does. In the first, the marker is ignored and the count only wraps at its bound. In the second, every marker clears the count. In the third, only the first marker after arming clears it. A step in which both phases flip together cannot be decoded. The block treats it as a count error: the count holds, a one-cycle interrupt pulse fires and a sticky flag latches until it is cleared by writing 1. Everything runs on one clock, and the configuration arrives as plain register-style inputs.

Top module: `qdec_position_unit`

## Requirements
- R1: After reset `pos_o`, `dir_o`, `err_sticky_o`, `err_irq_o` and `aux_filt_o` are all 0.
- R2: With filtered phases {A,B} following 00, 01, 11, 10, 00, each single-phase change adds one to `pos_o`, and the reverse order subtracts one. `dir_o` goes to 1 on an up step and to 0 on a down step, and keeps its value otherwise.
- R3: An up step taken at `pos_o` greater than or equal to `cfg_max_i` gives 0. A down step at 0 gives `cfg_max_i`. This holds in every mode.
- R4: Each of the four inputs (A, B, Z and the spare, the spare seen on `aux_filt_o`) takes a new level only after the synchronized input has differed from the filtered level for `cfg_filt_len_i` consecutive clocks. A pulse one clock shorter is discarded. A length of 0 passes every synchronized sample.
- R5: When both filtered phases change in the same cycle, `pos_o` and `dir_o` keep their values, `err_irq_o` is high for exactly that one event, and `err_sticky_o` becomes 1.
- R6: `err_sticky_o` stays set until `err_clr_i` is 1 in a cycle with no new error. A new error in the same cycle takes precedence.
- R7: With `cfg_mode_i` = 1, every rising edge of the filtered Z clears `pos_o` to 0. This takes precedence over a phase step in the same cycle.
- R8: With `cfg_mode_i` = 2, the mode is armed when it is entered from another mode or when `arm_once_i` is pulsed. Only the first filtered Z rising edge while armed clears `pos_o`, and later edges leave it unchanged.
- R9: With `cfg_mode_i` = 0 (or 3), Z edges leave `pos_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| enc_a_i | input | 1 | Raw phase A |
| enc_b_i | input | 1 | Raw phase B |
| enc_z_i | input | 1 | Raw index marker |
| enc_aux_i | input | 1 | Raw spare encoder line |
| cfg_filt_len_i | input | FILT_W | Filter stability length in clocks, 0 = bypass |
| cfg_mode_i | input | 2 | 0 wrap only, 1 every index, 2 first index, 3 as 0 |
| cfg_max_i | input | CNT_W | Upper bound of the position count |
| arm_once_i | input | 1 | Pulse to re-arm first-index mode |
| err_clr_i | input | 1 | Write-1 clear of the sticky error flag |
| pos_o | output | CNT_W | Position count |
| dir_o | output | 1 | Last step direction, 1 = up |
| err_sticky_o | output | 1 | Sticky count-error flag |
| err_irq_o | output | 1 | One-cycle count-error pulse |
| aux_filt_o | output | 1 | Filtered spare line |

## Verification
An index clear and a phase step can land in the same clock. Index mode defines the result: the clear wins. The bench provokes this by driving a phase change and the rising Z on the same clock edge with the filter bypassed. Both then leave the filters together and reach the counter in one cycle. The count must read 0 afterwards, not the pre-clear value plus one.

// File: rtl/qdec_pkg.sv
package qdec_pkg;

  localparam int QD_NUM_IN = 4;
  localparam int QD_CH_A   = 0;
  localparam int QD_CH_B   = 1;
  localparam int QD_CH_Z   = 2;
  localparam int QD_CH_AUX = 3;

  typedef enum logic [1:0] {
    MODE_WRAP  = 2'd0,
    MODE_INDEX = 2'd1,
    MODE_ONCE  = 2'd2,
    MODE_ALT   = 2'd3
  } qdec_mode_e;

  typedef struct packed {
    logic up;
    logic dn;
    logic bad;
  } qdec_step_t;

endpackage

// File: rtl/qdec_in_filter.sv
module qdec_in_filter #(
  parameter int FILT_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FILT_W-1:0] len_i,
  input  logic              raw_i,
  output logic              filt_o
);

  localparam int CW = FILT_W + 1;

  logic [SYNC_STAGES-1:0] sync_q, sync_n;
  logic [FILT_W-1:0]      cnt_q, cnt_n;
  logic                   out_q, out_n;
  logic                   sample;
  logic [CW-1:0]          cnt_inc;

  assign sample  = sync_q[SYNC_STAGES-1];
  assign cnt_inc = {1'b0, cnt_q} + CW'(1);

  always_comb begin
    sync_n = {sync_q[SYNC_STAGES-2:0], raw_i};
    out_n  = out_q;
    cnt_n  = cnt_q;
    if (len_i == '0) begin
      out_n = sample;
      cnt_n = '0;
    end else if (sample == out_q) begin
      cnt_n = '0;
    end else if (cnt_inc >= {1'b0, len_i}) begin
      out_n = sample;
      cnt_n = '0;
    end else begin
      cnt_n = cnt_inc[FILT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      cnt_q  <= '0;
      out_q  <= 1'b0;
    end else begin
      sync_q <= sync_n;
      cnt_q  <= cnt_n;
      out_q  <= out_n;
    end
  end

  assign filt_o = out_q;

endmodule

// File: rtl/qdec_step_decode.sv
module qdec_step_decode
  import qdec_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       a_i,
  input  logic       b_i,
  input  logic       z_i,
  output qdec_step_t step_o,
  output logic       z_rise_o
);

  logic       prev_a_q, prev_b_q, prev_z_q;
  logic [1:0] changed;

  assign changed = {a_i ^ prev_a_q, b_i ^ prev_b_q};

  always_comb begin
    step_o.up  = 1'b0;
    step_o.dn  = 1'b0;
    step_o.bad = 1'b0;
    unique case (changed)
      2'b00: ;
      2'b11: step_o.bad = 1'b1;
      default: begin
        if (prev_a_q ^ b_i) step_o.up = 1'b1;
        else                step_o.dn = 1'b1;
      end
    endcase
  end

  assign z_rise_o = z_i & ~prev_z_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_a_q <= 1'b0;
      prev_b_q <= 1'b0;
      prev_z_q <= 1'b0;
    end else begin
      prev_a_q <= a_i;
      prev_b_q <= b_i;
      prev_z_q <= z_i;
    end
  end

endmodule

// File: rtl/qdec_pos_counter.sv
module qdec_pos_counter
  import qdec_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  qdec_step_t       step_i,
  input  logic             z_rise_i,
  input  logic [1:0]       mode_i,
  input  logic [CNT_W-1:0] max_i,
  input  logic             arm_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] pos_o,
  output logic             dir_o,
  output logic             err_sticky_o,
  output logic             err_irq_o
);

  qdec_mode_e       mode, mode_q;
  logic [CNT_W-1:0] pos_q, pos_n;
  logic             dir_q, dir_n;
  logic             armed_q, armed_n;
  logic             sticky_q, sticky_n;
  logic             irq_q;
  logic             entering, idx_hit;

  assign mode     = qdec_mode_e'(mode_i);
  assign entering = (mode == MODE_ONCE) && (mode_q != MODE_ONCE);

  always_comb begin
    idx_hit = 1'b0;
    unique case (mode)
      MODE_INDEX: idx_hit = z_rise_i;
      MODE_ONCE:  idx_hit = z_rise_i && (armed_q || entering || arm_i);
      default:    idx_hit = 1'b0;
    endcase
  end

  always_comb begin
    pos_n = pos_q;
    dir_n = dir_q;
    if (step_i.up) dir_n = 1'b1;
    if (step_i.dn) dir_n = 1'b0;
    if (idx_hit) begin
      pos_n = '0;
    end else if (step_i.up) begin
      pos_n = (pos_q >= max_i) ? '0 : pos_q + CNT_W'(1);
    end else if (step_i.dn) begin
      pos_n = (pos_q == '0) ? max_i : pos_q - CNT_W'(1);
    end
  end

  always_comb begin
    armed_n = armed_q;
    if (idx_hit && (mode == MODE_ONCE)) armed_n = 1'b0;
    else if (entering || arm_i)         armed_n = 1'b1;
  end

  always_comb begin
    sticky_n = sticky_q;
    if (step_i.bad)  sticky_n = 1'b1;
    else if (clr_i)  sticky_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q    <= '0;
      dir_q    <= 1'b0;
      armed_q  <= 1'b0;
      sticky_q <= 1'b0;
      irq_q    <= 1'b0;
      mode_q   <= MODE_WRAP;
    end else begin
      pos_q    <= pos_n;
      dir_q    <= dir_n;
      armed_q  <= armed_n;
      sticky_q <= sticky_n;
      irq_q    <= step_i.bad;
      mode_q   <= mode;
    end
  end

  assign pos_o        = pos_q;
  assign dir_o        = dir_q;
  assign err_sticky_o = sticky_q;
  assign err_irq_o    = irq_q;

endmodule

// File: rtl/qdec_position_unit.sv
module qdec_position_unit
  import qdec_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int FILT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enc_a_i,
  input  logic              enc_b_i,
  input  logic              enc_z_i,
  input  logic              enc_aux_i,
  input  logic [FILT_W-1:0] cfg_filt_len_i,
  input  logic [1:0]        cfg_mode_i,
  input  logic [CNT_W-1:0]  cfg_max_i,
  input  logic              arm_once_i,
  input  logic              err_clr_i,
  output logic [CNT_W-1:0]  pos_o,
  output logic              dir_o,
  output logic              err_sticky_o,
  output logic              err_irq_o,
  output logic              aux_filt_o
);

  logic [QD_NUM_IN-1:0] raw_in, filt_in;
  qdec_step_t           step;
  logic                 z_rise;
  logic                 step_up, step_dn, step_bad;

  assign raw_in[QD_CH_A]   = enc_a_i;
  assign raw_in[QD_CH_B]   = enc_b_i;
  assign raw_in[QD_CH_Z]   = enc_z_i;
  assign raw_in[QD_CH_AUX] = enc_aux_i;

  for (genvar gi = 0; gi < QD_NUM_IN; gi++) begin : g_filt
    qdec_in_filter #(.FILT_W(FILT_W), .SYNC_STAGES(2)) u_filt (
      .clk    (clk),
      .rst_n  (rst_n),
      .len_i  (cfg_filt_len_i),
      .raw_i  (raw_in[gi]),
      .filt_o (filt_in[gi])
    );
  end

  qdec_step_decode u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .a_i      (filt_in[QD_CH_A]),
    .b_i      (filt_in[QD_CH_B]),
    .z_i      (filt_in[QD_CH_Z]),
    .step_o   (step),
    .z_rise_o (z_rise)
  );

  qdec_pos_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk          (clk),
    .rst_n        (rst_n),
    .step_i       (step),
    .z_rise_i     (z_rise),
    .mode_i       (cfg_mode_i),
    .max_i        (cfg_max_i),
    .arm_i        (arm_once_i),
    .clr_i        (err_clr_i),
    .pos_o        (pos_o),
    .dir_o        (dir_o),
    .err_sticky_o (err_sticky_o),
    .err_irq_o    (err_irq_o)
  );

  assign step_up    = step.up;
  assign step_dn    = step.dn;
  assign step_bad   = step.bad;
  assign aux_filt_o = filt_in[QD_CH_AUX];

endmodule

// File: rtl/qdec_position_unit_chk.sv
module qdec_position_unit_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             step_up,
  input logic             step_dn,
  input logic             step_bad,
  input logic             z_rise,
  input logic [1:0]       cfg_mode_i,
  input logic [CNT_W-1:0] cfg_max_i,
  input logic             err_clr_i,
  input logic [CNT_W-1:0] pos_o,
  input logic             dir_o,
  input logic             err_sticky_o,
  input logic             err_irq_o
);

  // R2
  up_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_up |=> dir_o);

  // R2
  dn_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_dn |=> !dir_o);

  // R3
  wrap_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_up && !z_rise && pos_o == cfg_max_i) |=> (pos_o == '0));

  // R5
  bad_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_bad && !z_rise) |=> $stable(pos_o));

  // R5
  bad_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_bad |=> (err_irq_o && err_sticky_o));

  // R6
  sticky_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clr_i && !step_bad) |=> !err_sticky_o);

  // R6
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_sticky_o && !err_clr_i) |=> err_sticky_o);

  // R7
  index_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (z_rise && cfg_mode_i == 2'd1) |=> (pos_o == '0));

  // R9
  wrap_ignores_z_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (z_rise && cfg_mode_i == 2'd0 && !step_up && !step_dn) |=> $stable(pos_o));

endmodule

bind qdec_position_unit qdec_position_unit_chk #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .step_up      (step_up),
  .step_dn      (step_dn),
  .step_bad     (step_bad),
  .z_rise       (z_rise),
  .cfg_mode_i   (cfg_mode_i),
  .cfg_max_i    (cfg_max_i),
  .err_clr_i    (err_clr_i),
  .pos_o        (pos_o),
  .dir_o        (dir_o),
  .err_sticky_o (err_sticky_o),
  .err_irq_o    (err_irq_o)
);

// File: tb/qdec_position_unit_tb.sv
module qdec_position_unit_tb;

  localparam int CNT_W  = 16;
  localparam int FILT_W = 4;
  localparam int NVEC   = 11;

  // {a, b, exp_dir, exp_sticky, exp_pos}; max = 5, wrap mode
  localparam logic [19:0] VEC [NVEC] = '{
    {1'b0, 1'b1, 1'b1, 1'b0, 16'd1},
    {1'b1, 1'b1, 1'b1, 1'b0, 16'd2},
    {1'b1, 1'b0, 1'b1, 1'b0, 16'd3},
    {1'b0, 1'b0, 1'b1, 1'b0, 16'd4},
    {1'b0, 1'b1, 1'b1, 1'b0, 16'd5},
    {1'b1, 1'b1, 1'b1, 1'b0, 16'd0},
    {1'b0, 1'b1, 1'b0, 1'b0, 16'd5},
    {1'b0, 1'b0, 1'b0, 1'b0, 16'd4},
    {1'b1, 1'b1, 1'b0, 1'b1, 16'd4},
    {1'b1, 1'b0, 1'b1, 1'b1, 16'd5},
    {1'b1, 1'b1, 1'b0, 1'b1, 16'd4}
  };

  logic              clk, rst_n;
  logic              enc_a, enc_b, enc_z, enc_aux;
  logic [FILT_W-1:0] filt_len;
  logic [1:0]        mode;
  logic [CNT_W-1:0]  max_cnt;
  logic              arm_once, err_clr;
  logic [CNT_W-1:0]  pos;
  logic              dir, err_sticky, err_irq, aux_filt;

  int checks = 0;
  int errors = 0;
  int irq_cnt = 0;
  bit done = 0;

  qdec_position_unit #(.CNT_W(CNT_W), .FILT_W(FILT_W)) u_dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .enc_a_i        (enc_a),
    .enc_b_i        (enc_b),
    .enc_z_i        (enc_z),
    .enc_aux_i      (enc_aux),
    .cfg_filt_len_i (filt_len),
    .cfg_mode_i     (mode),
    .cfg_max_i      (max_cnt),
    .arm_once_i     (arm_once),
    .err_clr_i      (err_clr),
    .pos_o          (pos),
    .dir_o          (dir),
    .err_sticky_o   (err_sticky),
    .err_irq_o      (err_irq),
    .aux_filt_o     (aux_filt)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) if (rst_n && err_irq) irq_cnt++;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    enc_a = 1'b0; enc_b = 1'b0; enc_z = 1'b0; enc_aux = 1'b0;
    arm_once = 1'b0; err_clr = 1'b0;
    wait_n(4);
    rst_n = 1'b1;
    wait_n(3);
  endtask

  task automatic set_ab(input logic a, input logic b);
    enc_a = a; enc_b = b;
    wait_n(8);
  endtask

  task automatic pulse_z();
    enc_z = 1'b1;
    wait_n(6);
    enc_z = 1'b0;
    wait_n(6);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    filt_len = '0; mode = 2'd0; max_cnt = 16'd5;
    do_reset();

    // R1 reset state
    check("R1", "pos", pos, 0);
    check("R1", "dir", dir, 0);
    check("R1", "sticky", err_sticky, 0);
    check("R1", "irq", err_irq, 0);
    check("R1", "aux", aux_filt, 0);

    // R2 R3 R5 table walk
    for (int i = 0; i < NVEC; i++) begin
      set_ab(VEC[i][19], VEC[i][18]);
      check("R2", $sformatf("pos vec%0d", i), pos, VEC[i][15:0]);
      check("R2", $sformatf("dir vec%0d", i), dir, VEC[i][17]);
      check("R5", $sformatf("sticky vec%0d", i), err_sticky, VEC[i][16]);
    end
    check("R5", "irq pulses", irq_cnt, 1);

    // R6 write-one clear
    err_clr = 1'b1;
    wait_n(1);
    err_clr = 1'b0;
    wait_n(2);
    check("R6", "sticky after clear", err_sticky, 0);

    // R4 filter length 6
    do_reset();
    filt_len = 4'd6;
    enc_a = 1'b1; wait_n(5); enc_a = 1'b0; wait_n(30);
    check("R4", "short glitch pos", pos, 0);
    check("R4", "short glitch dir", dir, 0);
    enc_a = 1'b1; wait_n(6); enc_a = 1'b0; wait_n(30);
    check("R4", "accepted pulse pos", pos, 0);
    check("R4", "accepted pulse dir", dir, 1);

    // R4 bypass: one-clock B pulse passes
    filt_len = 4'd0;
    wait_n(2);
    enc_b = 1'b1; wait_n(1); enc_b = 1'b0; wait_n(10);
    check("R4", "bypass pulse dir", dir, 0);
    check("R4", "bypass pulse pos", pos, 0);

    // R4 spare line filter
    filt_len = 4'd3;
    enc_aux = 1'b1; wait_n(2); enc_aux = 1'b0; wait_n(20);
    check("R4", "aux short", aux_filt, 0);
    enc_aux = 1'b1; wait_n(12);
    check("R4", "aux held", aux_filt, 1);
    enc_aux = 1'b0; wait_n(12);
    filt_len = 4'd0;
    wait_n(2);

    // R9 wrap mode ignores Z
    set_ab(1'b0, 1'b1);
    set_ab(1'b1, 1'b1);
    pulse_z();
    check("R9", "pos after Z", pos, 2);

    // R7 index mode
    mode = 2'd1;
    wait_n(2);
    pulse_z();
    check("R7", "first Z clear", pos, 0);
    set_ab(1'b1, 1'b0);
    set_ab(1'b0, 1'b0);
    check("R7", "count after clear", pos, 2);
    pulse_z();
    check("R7", "second Z clear", pos, 0);

    // R7 collision: phase step and Z in one cycle
    set_ab(1'b0, 1'b1);
    enc_a = 1'b1; enc_z = 1'b1;
    wait_n(8);
    enc_z = 1'b0;
    wait_n(8);
    check("R7", "clear beats step", pos, 0);

    // R8 first-index mode
    mode = 2'd2;
    wait_n(2);
    set_ab(1'b1, 1'b0);
    set_ab(1'b0, 1'b0);
    check("R8", "count before Z", pos, 2);
    pulse_z();
    check("R8", "first Z clears", pos, 0);
    set_ab(1'b0, 1'b1);
    set_ab(1'b1, 1'b1);
    pulse_z();
    check("R8", "second Z ignored", pos, 2);
    arm_once = 1'b1; wait_n(1); arm_once = 1'b0; wait_n(2);
    pulse_z();
    check("R8", "re-armed Z clears", pos, 0);

    done = 1;
    finish_run();
  end

endmodule